// File: doc/BRIEF.md
# Raster Refresh and Memory Slot Scheduler

This block does all of the timing for a bit-mapped frame store that holds 4096 words of 16 bits each. It reads the store out serially as a raster video stream. It also lets a plotting agent set single points in the store while the display runs. Each word period has 16 point ticks, and each tick is one clock on which the point-clock enable is high. In every word period the block schedules two memory slots. The first is a display read, which fetches the next word for the screen. The second is a read-modify-write slot, which ORs one point into a word without disturbing the other points already set in that word.

A 4-bit phase counter steps once per point tick. A horizontal sync input clears it. The counter value alone decides where each event falls in the word period: the display read, the shift-register load, the plot read with the display-address step, and the plot write-back. The memory sits outside the block. It is a synchronous array: it samples a read request on a clock edge and returns the data `RD_LAT` clocks later. `RD_LAT` may be 1 or 2. The display address covers the whole store once per field and then wraps. A single holding register accepts one plot request at a time through a valid/ready handshake.

Top module: `raster_slot_sched`

## Requirements
- R1: The phase counter starts at 0 after reset. It steps by one, modulo 16, on every clock with `pt_en` high. If `hsync` is high at a clock edge, the counter goes to 0 whatever `pt_en` is. Events are keyed to the counter value present on the tick.
- R2: A tick at phase 3 makes `mem_rd_en` high for exactly the next clock, with `mem_rd_addr` equal to the current display address. The word read is captured `RD_LAT` clocks after that request.
- R3: A tick at phase 8 loads the most recently fetched display word into a 16-bit shifter. `video` then shows word bit 15 and moves one bit lower, filling with zeros, on each later tick. Bit index 0 is therefore the leftmost point. `video` changes only on ticks.
- R4: The display address is 0 after reset. It rises by one on every tick at phase 11 and wraps from 4095 to 0. `hsync` does not alter it.
- R5: `plot_ready` is high exactly when the holding register is empty. A request with `plot_valid` high while `plot_ready` is high is captured (address and 4-bit bit index), and `plot_ready` falls on the next clock.
- R6: A tick at phase 11, while a request is held and no read-modify-write is in flight, makes `mem_rd_en` high for the next clock with `mem_rd_addr` equal to the held address.
- R7: A tick at phase 15, while a read-modify-write is in flight, makes `mem_wr_en` high for the next clock. In that clock `mem_wr_addr` equals the held address, and `mem_wr_data` equals the read word with bit (15 − bit index) set and all other bits unchanged. The holding register is empty from that clock on.
- R8: While no request is held, no plot read is issued and `mem_wr_en` stays low.
- R9: `rst` is synchronous and active high. While it is applied, `mem_rd_en`, `mem_wr_en` and `video` are low and `plot_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pt_en | input | 1 | Point-clock enable; one tick per high clock |
| hsync | input | 1 | Delayed horizontal sync; clears the phase counter |
| plot_valid | input | 1 | Plot request valid |
| plot_addr | input | ADDR_W (12) | Word address of the point to set |
| plot_bit | input | 4 | Bit index within the word, 0 = leftmost |
| plot_ready | output | 1 | Holding register empty |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W (12) | Memory read address |
| mem_rd_data | input | 16 | Memory read data, RD_LAT clocks after the request |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W (12) | Memory write address |
| mem_wr_data | output | 16 | Merged word to write back |
| video | output | 1 | Serial binary video |

## Verification
The bench targets the following corner cases:

- **Write-back merge.** The bench plots into words that already hold set bits, and plots the same point twice. A design that wrote a bare mask instead of the merged word would wipe out neighbouring points in both cases.
- **Edge bits of the word.** Bit indices 0 and 15 pin down the MSB-first mapping. A design with a reversed shifter or a reversed mask would show those points at the wrong screen edge.
- **Sync pulses at random phases.** These pulses restart the phase counter while a read-modify-write may be half done. A scheduler that lost or repeated the write-back, or that moved the display address on sync, would then disagree with the cycle model.
- **Holes in the point-clock enable and a full-field run.** The bench leaves random gaps in `pt_en` to catch events that fire on plain clocks rather than on ticks. It also runs long enough to cross the 4095-to-0 wrap of the display address.

// File: rtl/rss_pkg.sv
package rss_pkg;
  localparam int PH_W   = 4;
  localparam int WORD_W = 1 << PH_W;
  typedef logic [PH_W-1:0] phase_t;
  localparam phase_t PH_DISP_RD = 4'd3;
  localparam phase_t PH_LOAD    = 4'd8;
  localparam phase_t PH_SLOT2   = 4'd11;
  localparam phase_t PH_WRBACK  = 4'd15;
endpackage

// File: rtl/rss_phase_ctr.sv
module rss_phase_ctr
  import rss_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   pt_en,
  input  logic   hsync,
  output phase_t phase
);
  phase_t phase_q;

  always_ff @(posedge clk) begin
    if (rst || hsync) phase_q <= '0;
    else if (pt_en)   phase_q <= phase_q + 1'b1;
  end

  assign phase = phase_q;

  assert_sync_clears_R1: assert property (@(posedge clk) disable iff (rst)
    hsync |=> (phase_q == '0));
  assert_hold_without_tick_R1: assert property (@(posedge clk) disable iff (rst)
    (!hsync && !pt_en) |=> $stable(phase_q));
endmodule

// File: rtl/rss_display.sv
module rss_display
  import rss_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int RD_LAT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pt_en,
  input  phase_t            phase,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              video
);
  logic [ADDR_W-1:0] addr_q;
  logic [RD_LAT:0]   tag_q;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] shreg_q;

  assign rd_req  = pt_en && (phase == PH_DISP_RD);
  assign rd_addr = addr_q;
  assign video   = shreg_q[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      tag_q   <= '0;
      word_q  <= '0;
      shreg_q <= '0;
    end else begin
      tag_q <= {tag_q[RD_LAT-1:0], rd_req};
      if (tag_q[RD_LAT]) word_q <= mem_rd_data;
      if (pt_en && (phase == PH_SLOT2)) addr_q <= addr_q + 1'b1;
      if (pt_en) begin
        if (phase == PH_LOAD) shreg_q <= word_q;
        else                  shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  assert_video_only_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    !pt_en |=> $stable(video));
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (pt_en && (phase == PH_SLOT2)) |=> (addr_q == $past(addr_q) + 1'b1));
  assert_addr_still_R4: assert property (@(posedge clk) disable iff (rst)
    !pt_en |=> $stable(addr_q));
endmodule

// File: rtl/rss_plot_rmw.sv
module rss_plot_rmw
  import rss_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int RD_LAT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pt_en,
  input  phase_t            phase,
  input  logic              plot_valid,
  input  logic [ADDR_W-1:0] plot_addr,
  input  logic [PH_W-1:0]   plot_bit,
  output logic              plot_ready,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data
);
  logic              hold_v, busy;
  logic [ADDR_W-1:0] hold_addr;
  logic [PH_W-1:0]   hold_bit;
  logic [RD_LAT:0]   tag_q;
  logic [WORD_W-1:0] word_q, mask;
  logic              wr_fire;
  logic              wr_en_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [WORD_W-1:0] wr_data_q;

  // bit index 0 maps to the word MSB, the leftmost point
  assign mask       = {{(WORD_W-1){1'b0}}, 1'b1} << (~hold_bit);
  assign plot_ready = !hold_v;
  assign rd_req     = pt_en && (phase == PH_SLOT2) && hold_v && !busy;
  assign rd_addr    = hold_addr;
  assign wr_fire    = pt_en && (phase == PH_WRBACK) && busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v    <= 1'b0;
      busy      <= 1'b0;
      hold_addr <= '0;
      hold_bit  <= '0;
      tag_q     <= '0;
      word_q    <= '0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      tag_q   <= {tag_q[RD_LAT-1:0], rd_req};
      wr_en_q <= wr_fire;
      if (tag_q[RD_LAT]) word_q <= mem_rd_data;
      if (plot_valid && !hold_v) begin
        hold_v    <= 1'b1;
        hold_addr <= plot_addr;
        hold_bit  <= plot_bit;
      end
      if (rd_req) busy <= 1'b1;
      if (wr_fire) begin
        wr_addr_q <= hold_addr;
        wr_data_q <= word_q | mask;
        busy      <= 1'b0;
        hold_v    <= 1'b0;
      end
    end
  end

  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;

  assert_ready_drops_R5: assert property (@(posedge clk) disable iff (rst)
    (plot_valid && plot_ready) |=> !plot_ready);
  assert_write_needs_hold_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en_q |-> $past(hold_v));
  assert_single_write_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en_q |=> !wr_en_q);
endmodule

// File: rtl/raster_slot_sched.sv
module raster_slot_sched
  import rss_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int RD_LAT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pt_en,
  input  logic              hsync,
  input  logic              plot_valid,
  input  logic [ADDR_W-1:0] plot_addr,
  input  logic [PH_W-1:0]   plot_bit,
  output logic              plot_ready,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [WORD_W-1:0] mem_wr_data,
  output logic              video
);
  phase_t            phase;
  logic              disp_req, plot_req;
  logic [ADDR_W-1:0] disp_addr, plot_rd_addr;

  rss_phase_ctr u_phase (
    .clk(clk), .rst(rst), .pt_en(pt_en), .hsync(hsync), .phase(phase)
  );

  rss_display #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_disp (
    .clk(clk), .rst(rst), .pt_en(pt_en), .phase(phase),
    .mem_rd_data(mem_rd_data), .rd_req(disp_req), .rd_addr(disp_addr),
    .video(video)
  );

  rss_plot_rmw #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_plot (
    .clk(clk), .rst(rst), .pt_en(pt_en), .phase(phase),
    .plot_valid(plot_valid), .plot_addr(plot_addr), .plot_bit(plot_bit),
    .plot_ready(plot_ready), .mem_rd_data(mem_rd_data),
    .rd_req(plot_req), .rd_addr(plot_rd_addr),
    .wr_en(mem_wr_en), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
    end else begin
      mem_rd_en <= disp_req | plot_req;
      if (plot_req)      mem_rd_addr <= plot_rd_addr;
      else if (disp_req) mem_rd_addr <= disp_addr;
    end
  end

  assert_slots_disjoint_R2: assert property (@(posedge clk) disable iff (rst)
    !(disp_req && plot_req));
  assert_read_one_clock_R2: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);
  assert_rd_wr_apart_R7: assert property (@(posedge clk) disable iff (rst)
    $countones({mem_rd_en, mem_wr_en}) <= 1);
endmodule

// File: tb/raster_slot_sched_tb.sv
module raster_slot_sched_tb;
  localparam int AW = 12;
  localparam int NW = 1 << AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pt_en = 1'b0, hsync = 1'b0, plot_valid = 1'b0;
  logic [AW-1:0] plot_addr = '0;
  logic [3:0]  plot_bit = '0;
  logic        plot_ready, mem_rd_en, mem_wr_en, video;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [15:0] mem_rd_data, mem_wr_data;

  always #2.5 clk = ~clk;

  raster_slot_sched #(.ADDR_W(AW), .RD_LAT(1)) u_dut (
    .clk(clk), .rst(rst), .pt_en(pt_en), .hsync(hsync),
    .plot_valid(plot_valid), .plot_addr(plot_addr), .plot_bit(plot_bit),
    .plot_ready(plot_ready), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .video(video)
  );

  // frame store model, read latency one clock
  logic [15:0] bmem [0:NW-1];
  logic [15:0] rdata_q = '0;
  assign mem_rd_data = rdata_q;
  always @(posedge clk) begin
    if (mem_rd_en) rdata_q <= bmem[mem_rd_addr];
    if (mem_wr_en) bmem[mem_wr_addr] <= mem_wr_data;
  end

  int nchecks = 0, nerrors = 0;
  bit done = 0;

  function automatic logic [15:0] point_mask(input logic [3:0] b);
    return 16'h8000 >> b;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nerrors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // cycle model built from the requirements
  logic [3:0]  m_phase;
  logic [11:0] m_addr, m_haddr, last_disp;
  logic [15:0] m_sreg, m_snap;
  logic [3:0]  m_hbit;
  bit m_hold, m_busy, acc_flag, last_valid;
  bit exp_rd, exp_wr, exp_disp;
  logic [11:0] exp_rd_addr, exp_wr_addr;
  logic [15:0] exp_wr_data;
  int wraps = 0;

  always @(negedge clk) begin
    if (rst) begin
      m_phase = 0; m_addr = 0; m_sreg = 0; m_snap = 0; m_hold = 0; m_busy = 0;
      exp_rd = 0; exp_wr = 0; exp_disp = 0; acc_flag = 0; last_valid = 0;
      m_haddr = 0; m_hbit = 0; exp_rd_addr = 0; exp_wr_addr = 0; exp_wr_data = 0;
    end else begin
      bit tick, n_rd, n_wr, n_disp, was_hold;
      logic [11:0] n_rd_addr;
      chk(mem_rd_en == exp_rd, exp_disp || !exp_rd ? "R1 R2" : "R6",
          "read strobe", mem_rd_en, exp_rd);
      if (exp_rd)
        chk(mem_rd_addr == exp_rd_addr, exp_disp ? "R2 R4" : "R6",
            "read address", mem_rd_addr, exp_rd_addr);
      chk(mem_wr_en == exp_wr, exp_wr ? "R7" : "R8", "write strobe", mem_wr_en, exp_wr);
      if (exp_wr) begin
        chk(mem_wr_addr == exp_wr_addr, "R7", "write address", mem_wr_addr, exp_wr_addr);
        chk(mem_wr_data == exp_wr_data, "R7", "merged word", mem_wr_data, exp_wr_data);
      end
      chk(video == m_sreg[15], "R3", "video bit", video, m_sreg[15]);
      chk(plot_ready == !m_hold, "R5", "plot_ready", plot_ready, !m_hold);

      tick = pt_en; n_rd = 0; n_wr = 0; n_disp = 0; n_rd_addr = 0;
      was_hold = m_hold;
      if (tick && m_phase == 4'd3) begin
        n_rd = 1; n_disp = 1; n_rd_addr = m_addr; m_snap = bmem[m_addr];
        if (m_addr == 12'd0 && last_disp == 12'hFFF) wraps++;
        last_disp = m_addr;
      end
      if (tick && m_phase == 4'd11 && m_hold && !m_busy) begin
        n_rd = 1; n_rd_addr = m_haddr; m_busy = 1;
      end
      if (tick && m_phase == 4'd15 && m_busy) begin
        n_wr = 1; exp_wr_addr = m_haddr;
        exp_wr_data = bmem[m_haddr] | point_mask(m_hbit);
        m_busy = 0; m_hold = 0;
      end
      acc_flag = plot_valid && !was_hold;
      if (acc_flag) begin
        m_hold = 1; m_haddr = plot_addr; m_hbit = plot_bit;
      end
      if (tick) m_sreg = (m_phase == 4'd8) ? m_snap : {m_sreg[14:0], 1'b0};
      if (tick && m_phase == 4'd11) m_addr = m_addr + 1'b1;
      if (hsync) m_phase = 0;
      else if (tick) m_phase = m_phase + 1'b1;
      exp_rd = n_rd; exp_wr = n_wr; exp_disp = n_disp; exp_rd_addr = n_rd_addr;
    end
  end

  // point clock and sync driver
  initial begin
    int gap;
    gap = 2000;
    wait (!rst);
    while (!done) begin
      @(posedge clk); #1;
      pt_en = ($urandom % 5) != 0;
      gap--;
      if (gap <= 0) begin
        hsync = 1'b1;
        if (gap <= -2) begin
          hsync = 1'b0;
          gap = 2500 + int'($urandom % 2500);
        end
      end
    end
  end

  task automatic send_plot(input logic [11:0] a, input logic [3:0] b);
    plot_valid = 1'b1; plot_addr = a; plot_bit = b;
    do begin
      @(posedge clk); #1;
    end while (!acc_flag_seen());
    plot_valid = 1'b0;
  endtask

  function automatic bit acc_flag_seen();
    return acc_flag;
  endfunction

  initial begin
    int unused;
    unused = $urandom(32'd4242);
    for (int i = 0; i < NW; i++) bmem[i] = 16'($urandom & $urandom);
    bmem[5] = 16'h0100;
    last_disp = 12'h000;
    repeat (4) @(posedge clk);
    #1;
    @(negedge clk);
    chk(mem_rd_en == 1'b0, "R9", "reset rd_en", mem_rd_en, 0);
    chk(mem_wr_en == 1'b0, "R9", "reset wr_en", mem_wr_en, 0);
    chk(video == 1'b0, "R9", "reset video", video, 0);
    chk(plot_ready == 1'b1, "R9", "reset ready", plot_ready, 1);
    @(posedge clk); #1;
    rst = 1'b0;
    // directed corners: leftmost and rightmost bit, repeated point, top address
    send_plot(12'd5, 4'd0);
    send_plot(12'd5, 4'd15);
    send_plot(12'd5, 4'd0);
    send_plot(12'd4095, 4'd7);
    send_plot(12'd0, 4'd8);
    send_plot(12'd1, 4'd7);
    for (int k = 0; k < 1500; k++) begin
      repeat ($urandom % 40) @(posedge clk);
      #1;
      send_plot(12'($urandom), 4'($urandom));
    end
    while (wraps < 1 && $time < 900000) @(posedge clk);
    repeat (200) @(posedge clk);
    chk(wraps >= 1, "R4", "address wrap seen", wraps, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nerrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
      $finish;
    end
  end
endmodule